// File: doc/BRIEF.md
# Saturating Arithmetic Unit

This block is a 32-bit integer datapath for saturating arithmetic. On each cycle with `op_valid` high it runs one operation: signed or unsigned add or subtract with clamping, a plain add that only records signed overflow, or a clamp of a value to a bit width chosen at run time. The clamp can be signed or unsigned, and it can act on the whole word or on both 16-bit halves at once. The result is registered and appears one cycle later, qualified by `res_vld`.

Any clamp or overflow sets a shared sticky flag. A two-state machine holds the flag. In state `FLG_CLEAR` the flag is low. The transition `FLG_CLEAR -> FLG_HELD` is taken when an operation hits a bound and no clear is requested. The transition `FLG_HELD -> FLG_CLEAR` is taken only on `flag_clr`. In every other case the state is kept. Reset returns the machine to `FLG_CLEAR`. Software can read the flag after a run of operations and then clear it.

Top module: `sat_arith_unit`

## Requirements
- R1: A result issued with `op_valid` high at a rising edge appears on `res_out`, with `res_vld` high, after that edge. `res_vld` is low after an edge where `op_valid` was low. After reset, `res_out`, `res_vld` and `sticky` are all 0.
- R2: Opcode 0 is signed add. If the true signed sum does not fit in 32 bits, the result is 0x7FFFFFFF when `opnd_a` is non-negative and 0x80000000 when it is negative. Otherwise the result is the sum.
- R3: Opcode 1 is signed subtract `opnd_a - opnd_b`. It clamps in the same way as R2.
- R4: Opcode 2 is unsigned add. The result is 0xFFFFFFFF when the sum exceeds 32 bits, and the sum otherwise.
- R5: Opcode 3 is unsigned subtract. The result is 0 when `opnd_b` is greater than `opnd_a`, and the difference otherwise.
- R6: Opcode 4 returns the wrapped 32-bit sum unchanged. It raises the flag only when the signed sum does not fit.
- R7: Opcode 5 clamps the signed `opnd_a` (call it v) to the range from -(2^s) to 2^s-1, where s = `sat_width`.
- R8: Opcode 6 clamps v to the range 0 to 2^s-1. A negative v gives 0.
- R9: Opcodes 7 and 8 apply R7 and R8, respectively, to the sign-extended low half and high half of `opnd_a`. The low result goes to bits 15:0 and the high result to bits 31:16, each truncated to 16 bits.
- R10: Any clamp or overflow in R2 to R9 sets `sticky`. No operation clears it.
- R11: `flag_clr` clears `sticky` at the next edge. It wins over a set in the same cycle.
- R12: Opcodes 9 to 15 give a result of 0 and do not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation issue strobe |
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | First operand / value to clamp |
| opnd_b | input | 32 | Second operand |
| sat_width | input | 5 | Clamp width s |
| flag_clr | input | 1 | Clear the sticky flag |
| res_out | output | 32 | Registered result |
| res_vld | output | 1 | Result valid |
| sticky | output | 1 | Sticky saturation flag |

## Verification
Both the result and the flag change at the first rising edge after issue. The bench therefore drives at a falling edge and reads all three outputs at the next falling edge, which is exactly one edge later. Each sweep vector is preceded by a clear-only cycle, so the flag read after the operation reflects that operation alone. The tests of flag retention and clear priority chain operations back to back and sample after each edge. The sweeps cover 16 corner operands for every add and subtract opcode, and every width from 0 to 31 for every clamp opcode.

// File: rtl/sat_arith_pkg.sv
package sat_arith_pkg;
    typedef enum logic [3:0] {
        OP_SADD   = 4'd0,
        OP_SSUB   = 4'd1,
        OP_UADD   = 4'd2,
        OP_USUB   = 4'd3,
        OP_ADDF   = 4'd4,
        OP_SSATW  = 4'd5,
        OP_USATW  = 4'd6,
        OP_SSAT16 = 4'd7,
        OP_USAT16 = 4'd8
    } sat_op_e;

    typedef enum logic {
        FLG_CLEAR = 1'b0,
        FLG_HELD  = 1'b1
    } flag_state_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    input  logic         is_uns,
    input  logic         wrap_only,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] raw;
    logic         s_ovf;
    logic         u_ovf;
    logic [W-1:0] clamp_val;

    always_comb begin
        raw = do_sub ? (a - b) : (a + b);
        // sign-bit overflow rule: operand signs agree (add) or differ (sub)
        if (do_sub)
            s_ovf = (a[W-1] ^ b[W-1]) & (raw[W-1] ^ a[W-1]);
        else
            s_ovf = ~(a[W-1] ^ b[W-1]) & (raw[W-1] ^ a[W-1]);
        u_ovf = do_sub ? (raw > a) : (raw < a);
        if (is_uns)
            clamp_val = do_sub ? '0 : '1;
        else
            clamp_val = a[W-1] ? SMIN : SMAX;
    end

    always_comb begin
        ovf = is_uns ? u_ovf : s_ovf;
        if (wrap_only || !ovf)
            res = raw;
        else
            res = clamp_val;
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [SW-1:0] width,
    input  logic          is_uns,
    output logic [W-1:0]  res,
    output logic          hit
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0]        mask;
    logic signed [W-1:0] top;

    always_comb begin
        mask = (ONE << width) - ONE;
        top  = $signed(val) >>> width;
        res  = val;
        hit  = 1'b0;
        if (is_uns) begin
            if (val[W-1]) begin
                res = '0;
                hit = 1'b1;
            end else if (val > mask) begin
                res = mask;
                hit = 1'b1;
            end
        end else begin
            if (top > 0) begin
                res = mask;
                hit = 1'b1;
            end else if (top < -1) begin
                res = ~mask;
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_flag_fsm.sv
module sat_flag_fsm
    import sat_arith_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clr,
    output logic sticky
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: if (raise && !clr) state_d = FLG_HELD;
            FLG_HELD:  if (clr)           state_d = FLG_CLEAR;
            default:                      state_d = FLG_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb sticky = (state_q == FLG_HELD);

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !sticky); // R11
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !clr) |=> sticky); // R10
    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (raise && !clr) |=> sticky); // R10
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
    import sat_arith_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic [SW-1:0] sat_width,
    input  logic          flag_clr,
    output logic [W-1:0]  res_out,
    output logic          res_vld,
    output logic          sticky
);
    localparam int HW    = W / 2;
    localparam int LANES = 3;

    sat_op_e op_sel;
    logic    as_sub, as_uns, as_wrap, cl_uns;
    logic [W-1:0] as_res;
    logic         as_ovf;
    logic [W-1:0] lane_in  [LANES];
    logic [W-1:0] lane_res [LANES];
    logic         lane_hit [LANES];
    logic [W-1:0] nxt_res;
    logic         nxt_hit;
    logic [W-1:0] res_q;
    logic         vld_q;
    logic         lane_unused;

    always_comb begin
        op_sel  = sat_op_e'(op_code);
        as_sub  = (op_sel == OP_SSUB) || (op_sel == OP_USUB);
        as_uns  = (op_sel == OP_UADD) || (op_sel == OP_USUB);
        as_wrap = (op_sel == OP_ADDF);
        cl_uns  = (op_sel == OP_USATW) || (op_sel == OP_USAT16);
    end

    sat_addsub #(.W(W)) u_addsub (
        .a(opnd_a), .b(opnd_b), .do_sub(as_sub), .is_uns(as_uns),
        .wrap_only(as_wrap), .res(as_res), .ovf(as_ovf)
    );

    // lane 0: whole word, lane 1: low half, lane 2: high half
    always_comb begin
        lane_in[0] = opnd_a;
        lane_in[1] = {{HW{opnd_a[HW-1]}}, opnd_a[HW-1:0]};
        lane_in[2] = {{HW{opnd_a[W-1]}},  opnd_a[W-1:HW]};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sat_clamp #(.W(W), .SW(SW)) u_clamp (
            .val(lane_in[g]), .width(sat_width), .is_uns(cl_uns),
            .res(lane_res[g]), .hit(lane_hit[g])
        );
    end

    assign lane_unused = ^{lane_res[1][W-1:HW], lane_res[2][W-1:HW]};

    always_comb begin
        nxt_res = '0;
        nxt_hit = 1'b0;
        unique case (op_sel)
            OP_SADD, OP_SSUB, OP_UADD, OP_USUB, OP_ADDF: begin
                nxt_res = as_res;
                nxt_hit = as_ovf;
            end
            OP_SSATW, OP_USATW: begin
                nxt_res = lane_res[0];
                nxt_hit = lane_hit[0];
            end
            OP_SSAT16, OP_USAT16: begin
                nxt_res = {lane_res[2][HW-1:0], lane_res[1][HW-1:0]};
                nxt_hit = lane_hit[1] | lane_hit[2];
            end
            default: begin
                nxt_res = '0;
                nxt_hit = 1'b0;
            end
        endcase
    end

    sat_flag_fsm u_flag (
        .clk(clk), .rst_n(rst_n), .raise(op_valid & nxt_hit),
        .clr(flag_clr), .sticky(sticky)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= op_valid;
            if (op_valid) res_q <= nxt_res;
        end
    end

    always_comb begin
        res_out = res_q;
        res_vld = vld_q;
    end

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_vld); // R1
    AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_vld); // R1
    AST_UADD_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd2) |=> (res_out >= $past(opnd_a))); // R4
    AST_USUB_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd3) |=> (res_out <= $past(opnd_a))); // R5
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code > 4'd8) |=> (res_out == '0)); // R12
endmodule

// File: tb/sim_sat_arith_unit.sv
module sim_sat_arith_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  sat_width = '0;
    logic        flag_clr = 1'b0;
    logic [31:0] res_out;
    logic        res_vld;
    logic        sticky;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_arith_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_width(sat_width),
        .flag_clr(flag_clr), .res_out(res_out), .res_vld(res_vld),
        .sticky(sticky)
    );

    function automatic logic [31:0] corner(input int i);
        case (i)
            0: return 32'h0000_0000;  1: return 32'h0000_0001;
            2: return 32'h0000_0002;  3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;  5: return 32'hFFFF_FFFF;
            6: return 32'hFFFF_FFFE;  7: return 32'h7FFF_FFFE;
            8: return 32'h8000_0001;  9: return 32'h0000_FFFF;
            10: return 32'h0000_8000; 11: return 32'h0000_7FFF;
            12: return 32'hFFFF_8000; 13: return 32'h1234_5678;
            14: return 32'hEDCB_A987; default: return 32'h4000_0000;
        endcase
    endfunction

    function automatic void clampv(input longint v, input int s, input bit uns,
                                   output logic [31:0] r, output bit f);
        longint hi = (longint'(1) << s) - 1;
        longint lo = uns ? 0 : -(longint'(1) << s);
        f = 1'b1;
        if (v > hi)      r = hi[31:0];
        else if (v < lo) r = lo[31:0];
        else begin r = v[31:0]; f = 1'b0; end
    endfunction

    function automatic void model(input int op, input logic [31:0] a,
                                  input logic [31:0] b, input int s,
                                  output logic [31:0] r, output bit f);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ua = longint'({32'd0, a});
        longint ub = longint'({32'd0, b});
        longint t;
        logic [31:0] rl, rh;
        bit fl, fh;
        r = '0; f = 1'b0;
        case (op)
            0, 1: begin
                t = (op == 0) ? sa + sb : sa - sb;
                if (t > 64'sd2147483647 || t < -64'sd2147483648) begin
                    f = 1'b1;
                    r = (sa < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
                end else r = t[31:0];
            end
            2: begin t = ua + ub; f = t > 64'hFFFF_FFFF; r = f ? 32'hFFFF_FFFF : t[31:0]; end
            3: begin t = ua - ub; f = t < 0; r = f ? 32'h0 : t[31:0]; end
            4: begin
                t = sa + sb; r = t[31:0];
                f = (t > 64'sd2147483647 || t < -64'sd2147483648);
            end
            5: clampv(sa, s, 1'b0, r, f);
            6: clampv(sa, s, 1'b1, r, f);
            7, 8: begin
                clampv(longint'($signed(a[15:0])),  s, op == 8, rl, fl);
                clampv(longint'($signed(a[31:16])), s, op == 8, rh, fh);
                r = {rh[15:0], rl[15:0]};
                f = fl | fh;
            end
            default: begin r = '0; f = 1'b0; end
        endcase
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive at falling edge; one rising edge later sample at the next falling edge
    task automatic issue(input int op, input logic [31:0] a, input logic [31:0] b,
                         input int s, input bit clr);
        op_valid = 1'b1; op_code = op[3:0]; opnd_a = a; opnd_b = b;
        sat_width = s[4:0]; flag_clr = clr;
        @(negedge clk);
        op_valid = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic vec(input string req, input int op, input logic [31:0] a,
                       input logic [31:0] b, input int s);
        logic [31:0] er; bit ef;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        model(op, a, b, s, er, ef);
        issue(op, a, b, s, 1'b0);
        check32(req, res_out, er);
        check1(req, sticky, ef);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] er; bit ef;
        repeat (3) @(negedge clk);
        // R1: reset state
        check32("R1 reset res", res_out, 32'h0);
        check1("R1 reset vld", res_vld, 1'b0);
        check1("R1 reset sticky", sticky, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: timing of valid
        issue(0, 32'd5, 32'd7, 0, 1'b0);
        check1("R1 vld high", res_vld, 1'b1);
        check32("R1 result", res_out, 32'd12);
        @(negedge clk);
        check1("R1 vld low", res_vld, 1'b0);

        // R2..R6 sweep
        for (int op = 0; op < 5; op++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++) begin
                    case (op)
                        0: vec("R2 sadd", op, corner(i), corner(j), 0);
                        1: vec("R3 ssub", op, corner(i), corner(j), 0);
                        2: vec("R4 uadd", op, corner(i), corner(j), 0);
                        3: vec("R5 usub", op, corner(i), corner(j), 0);
                        default: vec("R6 addf", op, corner(i), corner(j), 0);
                    endcase
                end

        // R7..R9 sweep over every width
        for (int op = 5; op < 9; op++)
            for (int s = 0; s < 32; s++)
                for (int i = 0; i < 16; i++) begin
                    case (op)
                        5: vec("R7 ssat", op, corner(i), 32'h0, s);
                        6: vec("R8 usat", op, corner(i), 32'h0, s);
                        default: vec("R9 halves", op, corner(i), 32'h0, s);
                    endcase
                end

        // R12: spare opcodes
        for (int op = 9; op < 16; op++)
            vec("R12 spare", op, 32'h8000_0000, 32'h8000_0000, 3);

        // R10: flag survives a later clean operation
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        issue(2, 32'hFFFF_FFFF, 32'd1, 0, 1'b0);
        check1("R10 set", sticky, 1'b1);
        issue(0, 32'd1, 32'd1, 0, 1'b0);
        check32("R10 clean result", res_out, 32'd2);
        check1("R10 held", sticky, 1'b1);
        issue(12, 32'd0, 32'd0, 0, 1'b0);
        check1("R10 held spare", sticky, 1'b1);

        // R11: clear beats set in the same cycle
        issue(0, 32'h7FFF_FFFF, 32'd1, 0, 1'b1);
        model(0, 32'h7FFF_FFFF, 32'd1, 0, er, ef);
        check32("R11 result", res_out, er);
        check1("R11 clear wins", sticky, 1'b0);
        issue(3, 32'd0, 32'd1, 0, 1'b0);
        check1("R11 set again", sticky, 1'b1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        check1("R11 clear alone", sticky, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule